// File: doc/BRIEF.md
# Framed Byte-Stream Receiver with Port Dispatch and CRC Check

The block takes bytes from a link PHY over a valid/ready handshake and looks for a fixed 32-bit start pattern. After the pattern it reads a destination byte and a 32-bit length. It then forwards the payload to one of several user ports, picking the port from the destination value. The length counts the payload plus the four trailing check bytes. The check bytes are a standard reflected CRC-32 computed over the payload alone, and they never reach the user port.

A four-byte holding line keeps the newest input bytes back. Because of this, a payload byte leaves only when the byte four positions after it has arrived. As a result, the last-byte marker falls on the final payload byte. The CRC verdict is also known in that same cycle, so the error flag is presented together with the last payload byte. When the selected user port is not ready, the block lowers the PHY ready signal, so no byte is lost or repeated. A destination that maps to no port causes the whole packet to be absorbed silently.

Top module: `pkt_deframer`

## Requirements
- R1: A packet starts with the bytes 0xA5, 0x5A, 0xA5, 0x5A in that order, which is the value 0x5AA55AA5 sent least significant byte first. Only after all four bytes match is the next byte taken as the destination.
- R2: When a start-pattern byte does not match, the search restarts at the first pattern byte, and the search resumes with the byte that follows the mismatching one. The mismatching byte itself is never examined again as the start of a new pattern.
- R3: After the start pattern come one destination byte and four length bytes, least significant byte first. Once the header has been read, port_dest and port_len hold these values until the next header.
- R4: Destinations 0x10 to 0x13 select user port index (destination − 0x10). Only that port's port_valid bit is raised. Any other destination delivers nothing on any port, and the packet's bytes are still consumed.
- R5: A packet delivers exactly (length − 4) payload bytes, in arrival order, and strips the four CRC bytes. A length of 4 or less delivers no byte.
- R6: port_first is high on the first payload byte and port_last is high on the final payload byte. A one-byte payload carries both markers on the same beat.
- R7: port_crc_err is high together with port_last exactly when the received CRC differs from the CRC-32 of the payload bytes. That CRC uses the reflected polynomial 0xEDB88320, an initial value of 0xFFFFFFFF and a final inversion, it is sent least significant byte first, and it excludes the header. The flag is low on every other beat.
- R8: While a payload byte is offered and the selected port's ready is low, phy_ready is low. The byte is then delivered unchanged once that port becomes ready.
- R9: During reset no port_valid bit is high and phy_ready is high.
- R10: After the last byte of a packet, the receiver hunts for a start pattern again at once, so a packet that follows back-to-back is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phy_valid | input | 1 | PHY byte valid |
| phy_data | input | 8 | PHY byte |
| phy_ready | output | 1 | Block accepts the PHY byte |
| port_valid | output | NUM_PORTS | Payload byte valid, one bit per user port |
| port_ready | input | NUM_PORTS | User port ready, one bit per port |
| port_data | output | 8 | Payload byte, shared by all ports |
| port_first | output | 1 | First payload byte of the packet |
| port_last | output | 1 | Final payload byte of the packet |
| port_dest | output | 8 | Destination byte of the current packet |
| port_len | output | 32 | Length field of the current packet |
| port_crc_err | output | 1 | CRC mismatch, presented with port_last |

## Verification
On every cycle, the in-line assertions check four things. At most one port is driven. A stalled payload byte always holds phy_ready low. Entry into the header follows a final pattern byte of 0x5A. The parser returns to hunting immediately after a packet's last byte. They also check that the holding line never overfills and that the first marker clears after its beat. Only the bench scenarios can show the rest. This covers the exact payload contents and their order, the stripping of the CRC bytes and a correct CRC verdict on good and corrupted packets. It also covers the no-reconsider rule of the pattern search, silent absorption for unmapped destinations, zero- and one-byte payloads, and lossless delivery under a stalling port.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DEST = 2'd1,
    ST_LEN  = 2'd2,
    ST_PAY  = 2'd3
  } pd_state_e;

  localparam logic [31:0] START_WORD = 32'h5AA55AA5;
  localparam int          START_BYTES = 4;
  localparam int          CRC_BYTES   = 4;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/pd_hdr_fsm.sv
module pd_hdr_fsm
  import pkt_deframer_pkg::*;
#(
  parameter int LEN_BYTES = 4,
  parameter int DEST_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc,
  input  logic [7:0]             byte_in,
  output pd_state_e              st,
  output logic                   pay_start,
  output logic                   pay_last,
  output logic [DEST_W-1:0]      dest,
  output logic [8*LEN_BYTES-1:0] len
);
  localparam int LEN_W = 8 * LEN_BYTES;
  localparam int MAXB  = (LEN_BYTES > START_BYTES) ? LEN_BYTES : START_BYTES;
  localparam int IDX_W = (MAXB > 1) ? $clog2(MAXB) : 1;

  pd_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [7:0]        pat_byte;

  assign pat_byte = 8'(START_WORD >> {idx_q, 3'b000});

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    dest_d    = dest_q;
    len_d     = len_q;
    rem_d     = rem_q;
    pay_start = 1'b0;
    if (acc) begin
      case (st_q)
        ST_HUNT: begin
          if (byte_in == pat_byte) begin
            if (idx_q == IDX_W'(START_BYTES - 1)) begin
              idx_d = '0;
              st_d  = ST_DEST;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            idx_d = '0;
          end
        end
        ST_DEST: begin
          dest_d = DEST_W'(byte_in);
          len_d  = '0;
          idx_d  = '0;
          st_d   = ST_LEN;
        end
        ST_LEN: begin
          len_d = len_q | (LEN_W'(byte_in) << {idx_q, 3'b000});
          if (idx_q == IDX_W'(LEN_BYTES - 1)) begin
            idx_d = '0;
            rem_d = len_d;
            if (len_d == '0) begin
              st_d = ST_HUNT;
            end else begin
              st_d      = ST_PAY;
              pay_start = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: begin
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) st_d = ST_HUNT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      idx_q  <= '0;
      dest_q <= '0;
      len_q  <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      dest_q <= dest_d;
      len_q  <= len_d;
      rem_q  <= rem_d;
    end
  end

  assign st       = st_q;
  assign pay_last = (st_q == ST_PAY) && (rem_q == LEN_W'(1));
  assign dest     = dest_q;
  assign len      = len_q;

  AST_HDR_AFTER_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEST && $past(st_q) == ST_HUNT) |-> ($past(acc) && $past(byte_in) == START_WORD[31:24])); // R1

  AST_HUNT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY && acc && rem_q == LEN_W'(1)) |=> (st_q == ST_HUNT)); // R10

  AST_PAY_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |-> (rem_q != '0)); // R5
endmodule

// File: rtl/pd_tail_line.sv
module pd_tail_line
  import pkt_deframer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pay_start,
  input  logic       shift,
  input  logic       emit_hs,
  input  logic [7:0] byte_in,
  output logic       full,
  output logic [7:0] head,
  output logic       first_pend,
  output logic       crc_bad
);
  localparam int DEPTH = CRC_BYTES;
  localparam int FW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][7:0] line_q, line_d;
  logic [FW-1:0]         fill_q, fill_d;
  logic [31:0]           crc_q, crc_d;
  logic                  first_q, first_d;
  logic [31:0]           crc_fin;
  logic [31:0]           rx_crc;

  assign full = (fill_q == FW'(DEPTH));

  always_comb begin
    line_d  = line_q;
    fill_d  = fill_q;
    crc_d   = crc_q;
    first_d = first_q;
    if (pay_start) begin
      fill_d  = '0;
      crc_d   = CRC_INIT;
      first_d = 1'b1;
    end else if (shift) begin
      for (int i = 0; i < DEPTH - 1; i++) line_d[i] = line_q[i+1];
      line_d[DEPTH-1] = byte_in;
      if (!full) fill_d = fill_q + 1'b1;
      else       crc_d  = crc32_step(crc_q, line_q[0]);
      if (emit_hs) first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      fill_q  <= '0;
      crc_q   <= CRC_INIT;
      first_q <= 1'b0;
    end else begin
      line_q  <= line_d;
      fill_q  <= fill_d;
      crc_q   <= crc_d;
      first_q <= first_d;
    end
  end

  assign crc_fin    = crc32_step(crc_q, line_q[0]) ^ 32'hFFFFFFFF;
  assign rx_crc     = {byte_in, line_q[DEPTH-1:1]};
  assign crc_bad    = (crc_fin != rx_crc);
  assign head       = line_q[0];
  assign first_pend = first_q;

  AST_LINE_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(DEPTH)); // R5

  AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_hs && first_q && !pay_start) |=> !first_q); // R6
endmodule

// File: rtl/pd_port_sel.sv
module pd_port_sel #(
  parameter int         NUM_PORTS = 4,
  parameter logic [7:0] PORT_BASE = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           dest,
  input  logic                 emit,
  input  logic [NUM_PORTS-1:0] ready_in,
  output logic [NUM_PORTS-1:0] valid_out,
  output logic                 routed,
  output logic                 sel_ready
);
  localparam logic [7:0] NP8 = 8'(NUM_PORTS);

  logic [7:0]           diff;
  logic [NUM_PORTS-1:0] match;

  assign diff   = dest - PORT_BASE;
  assign routed = (dest >= PORT_BASE) && (diff < NP8);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign match[i]     = routed && (diff == 8'(i));
    assign valid_out[i] = emit && match[i];
  end

  assign sel_ready = |(ready_in & match);

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valid_out)); // R4
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframer_pkg::*;
#(
  parameter int         NUM_PORTS = 4,
  parameter logic [7:0] PORT_BASE = 8'h10,
  parameter int         LEN_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   phy_valid,
  input  logic [7:0]             phy_data,
  output logic                   phy_ready,
  output logic [NUM_PORTS-1:0]   port_valid,
  input  logic [NUM_PORTS-1:0]   port_ready,
  output logic [7:0]             port_data,
  output logic                   port_first,
  output logic                   port_last,
  output logic [7:0]             port_dest,
  output logic [8*LEN_BYTES-1:0] port_len,
  output logic                   port_crc_err
);
  logic      rst_s_n;
  pd_state_e st;
  logic      acc, in_pay, emit, emit_hs, shift;
  logic      pay_start, pay_last;
  logic      full, first_pend, crc_bad;
  logic      routed, sel_ready;
  logic [7:0] head;

  pd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign in_pay    = (st == ST_PAY);
  assign emit      = in_pay && phy_valid && full;
  assign phy_ready = (in_pay && full && routed) ? sel_ready : 1'b1;
  assign acc       = phy_valid && phy_ready;
  assign shift     = acc && in_pay;
  assign emit_hs   = emit && routed && sel_ready;

  pd_hdr_fsm #(
    .LEN_BYTES (LEN_BYTES),
    .DEST_W    (8)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .acc       (acc),
    .byte_in   (phy_data),
    .st        (st),
    .pay_start (pay_start),
    .pay_last  (pay_last),
    .dest      (port_dest),
    .len       (port_len)
  );

  pd_tail_line u_tail (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .pay_start  (pay_start),
    .shift      (shift),
    .emit_hs    (emit_hs),
    .byte_in    (phy_data),
    .full       (full),
    .head       (head),
    .first_pend (first_pend),
    .crc_bad    (crc_bad)
  );

  pd_port_sel #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_BASE (PORT_BASE)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .dest      (port_dest),
    .emit      (emit),
    .ready_in  (port_ready),
    .valid_out (port_valid),
    .routed    (routed),
    .sel_ready (sel_ready)
  );

  assign port_data    = head;
  assign port_first   = emit && first_pend;
  assign port_last    = emit && pay_last;
  assign port_crc_err = emit && pay_last && crc_bad;

  AST_STALL_HOLDS_PHY: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((|port_valid) && !(|(port_valid & port_ready))) |-> !phy_ready); // R8

  AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((|(port_valid & port_ready)) && port_last) |=> !(|port_valid)); // R6
endmodule

// File: tb/pkt_deframer_test.sv
module pkt_deframer_test;
  localparam int         NP   = 4;
  localparam logic [7:0] BASE = 8'h10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          phy_valid;
  logic [7:0]    phy_data;
  logic          phy_ready;
  logic [NP-1:0] port_valid;
  logic [NP-1:0] port_ready;
  logic [7:0]    port_data;
  logic          port_first, port_last, port_crc_err;
  logic [7:0]    port_dest;
  logic [31:0]   port_len;

  always #5 clk = ~clk;

  pkt_deframer #(.NUM_PORTS(NP), .PORT_BASE(BASE), .LEN_BYTES(4)) uut (
    .clk(clk), .rst_n(rst_n), .phy_valid(phy_valid), .phy_data(phy_data),
    .phy_ready(phy_ready), .port_valid(port_valid), .port_ready(port_ready),
    .port_data(port_data), .port_first(port_first), .port_last(port_last),
    .port_dest(port_dest), .port_len(port_len), .port_crc_err(port_crc_err)
  );

  typedef struct {
    int         port;
    logic [7:0] data;
    bit         first;
    bit         last;
    bit         err;
  } beat_t;

  beat_t expq[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;
  bit in_reset = 1;
  bit stall_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] p[$]);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    foreach (p[k]) begin
      c = c ^ {24'd0, p[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // ready pattern for the user ports
  always @(posedge clk) begin
    cyc++;
    #1;
    port_ready = (stall_mode && (cyc % 3 != 0)) ? '0 : '1;
  end

  // output scoreboard, sampled away from the active edge
  always @(negedge clk) begin
    if (!in_reset) begin
      if ($countones(port_valid) > 1)
        check(0, "R4", "more than one port valid", port_valid, 0);
      if ((|port_valid) && !(|(port_valid & port_ready)) && phy_ready)
        check(0, "R8", "phy_ready high during stall", phy_ready, 0);
      for (int i = 0; i < NP; i++) begin
        if (port_valid[i] && port_ready[i]) begin
          if (expq.size() == 0) begin
            check(0, "R4", "unexpected beat on port", i, -1);
          end else begin
            beat_t e;
            e = expq.pop_front();
            check(i == e.port, "R4", "port index", i, e.port);
            check(port_data == e.data, "R5", "payload byte", port_data, e.data);
            check(port_first == e.first, "R6", "first marker", port_first, e.first);
            check(port_last == e.last, "R6", "last marker", port_last, e.last);
            check(port_crc_err == e.err, "R7", "crc error flag", port_crc_err, e.err);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    bit got;
    phy_data  = b;
    phy_valid = 1'b1;
    got = 0;
    while (!got) begin
      @(negedge clk);
      got = phy_ready;
      @(posedge clk);
      #2;
    end
    phy_valid = 1'b0;
  endtask

  task automatic send_packet(input logic [7:0] dest, input int n, input bit bad,
                             input bit expect_out, input bit hdr_check, input int seed);
    logic [7:0]  pay[$];
    logic [31:0] crc, len;
    int          port;
    for (int k = 0; k < n; k++) pay.push_back(8'((seed + k * 7) & 8'h3F));
    crc = ref_crc(pay);
    if (bad) crc = crc ^ 32'h0000_0100;
    len = 32'(n + 4);
    port = int'(dest) - int'(BASE);
    if (expect_out && port >= 0 && port < NP) begin
      for (int k = 0; k < n; k++) begin
        beat_t e;
        e.port  = port;
        e.data  = pay[k];
        e.first = (k == 0);
        e.last  = (k == n - 1);
        e.err   = (k == n - 1) && bad;
        expq.push_back(e);
      end
    end
    send_byte(8'hA5); send_byte(8'h5A); send_byte(8'hA5); send_byte(8'h5A);
    send_byte(dest);
    for (int k = 0; k < 4; k++) send_byte(8'(len >> (8 * k)));
    foreach (pay[k]) send_byte(pay[k]);
    for (int k = 0; k < 4; k++) send_byte(8'(crc >> (8 * k)));
    check(expq.size() == 0, "R5", "beats left undelivered", expq.size(), 0);
    expq.delete();
    if (hdr_check) begin
      check(port_dest == dest, "R3", "port_dest", port_dest, dest);
      check(port_len == len, "R3", "port_len", port_len, len);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    phy_valid = 1'b0;
    phy_data = 8'h00;
    port_ready = '1;
    repeat (3) @(negedge clk);
    check(port_valid == '0, "R9", "port_valid in reset", port_valid, 0);
    check(phy_ready == 1'b1, "R9", "phy_ready in reset", phy_ready, 1);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    in_reset = 0;

    // R1 R3 R5 R6 R7: good packet to port 2
    send_packet(8'h12, 16, 0, 1, 1, 3);
    // R7: corrupted CRC flagged on the last byte
    send_packet(8'h10, 9, 1, 1, 1, 11);
    // R8: stalling user port
    stall_mode = 1;
    send_packet(8'h13, 24, 0, 1, 1, 5);
    stall_mode = 0;
    // R2: partial pattern then mismatch, search restarts
    send_byte(8'h00); send_byte(8'hA5); send_byte(8'h5A); send_byte(8'h00);
    send_packet(8'h11, 6, 0, 1, 1, 9);
    // R2: extra leading 0xA5 loses the packet (mismatching byte not reused)
    send_byte(8'hA5);
    send_packet(8'h12, 5, 0, 0, 0, 2);
    send_byte(8'h00); send_byte(8'h00);
    send_packet(8'h12, 3, 0, 1, 1, 7);
    // R4: unmapped destination absorbed silently, next packet still routed
    send_packet(8'h20, 7, 0, 1, 1, 4);
    send_packet(8'h13, 4, 0, 1, 1, 8);
    // R5 R6 R10: empty payload, then one-byte payload back-to-back
    send_packet(8'h11, 0, 0, 1, 1, 1);
    send_packet(8'h11, 1, 0, 1, 1, 6);
    // R10: back-to-back packets, second with bad CRC (R7)
    send_packet(8'h10, 3, 0, 1, 1, 12);
    send_packet(8'h12, 8, 1, 1, 1, 13);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule